// File: doc/BRIEF.md
# Indirect Branch Target Predictor

This block predicts where an indirect branch will go when that branch is not a subroutine return. It holds one direct-mapped table that all active hardware threads share. The table is indexed by XORing low fetch-address bits with global branch history bits, so one branch site that jumps to different places under different histories can use more than one slot. Each slot holds a full predicted target and a small saturating confidence counter. A target is offered for use only once it has proved itself. A stored target is not evicted on the first wrong resolution.

Fetch logic presents a lookup with the address bits and history of the fetch. On the next clock the block returns a usable flag, the stored target and its confidence. When a branch resolves, the back end sends an update with the same index inputs and the real target. The block compares that target with the stored one and decides, from the confidence, whether to strengthen, weaken or replace the slot. Return instructions are marked on both ports. The table ignores them, because a separate return stack predicts returns.

Top module: `itc_predictor`

## Requirements
- R1: The slot is selected by `fa ^ fold(hist)`. Both operands are IDX_W bits wide (7 bits, 128 slots by default). Any (fa, hist) pair with the same XOR reaches the same slot. There is no per-thread partition.
- R2: A lookup (`lk_valid`=1, `lk_is_ret`=0) returns its result on the clock after it is presented. `pr_valid` is 1 only if the slot is valid and its confidence is at least USE_MIN (2). `pr_conf` and `pr_target` show the slot's counter and target whenever the slot is valid.
- R3: An update to an invalid slot writes the resolved target, marks the slot valid and sets confidence to 1.
- R4: An update whose target equals the stored target raises confidence by one. Confidence saturates at 3.
- R5: An update whose target differs from the stored target, on a slot with confidence above 0, lowers confidence by one and keeps the stored target.
- R6: An update whose target differs from the stored target, on a slot with confidence 0, replaces the target and sets confidence to 1.
- R7: Requests marked as returns (`lk_is_ret`/`up_is_ret`=1) neither read nor modify the table. A return lookup yields `pr_valid`=0, `pr_conf`=0 and `pr_target`=0.
- R8: A synchronous active-high `rst` invalidates every slot and clears all outputs to 0.
- R9: When a lookup and an update hit the same slot in the same cycle, the lookup returns the slot contents as they were before that update.
- R10: A cycle with `lk_valid`=0 yields `pr_valid`=0, `pr_conf`=0 and `pr_target`=0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request |
| lk_is_ret | input | 1 | Lookup belongs to a subroutine return |
| lk_fa | input | IDX_W | Fetch-address index bits of the lookup |
| lk_hist | input | HIST_W | Global history of the lookup |
| up_valid | input | 1 | Update request |
| up_is_ret | input | 1 | Update belongs to a subroutine return |
| up_fa | input | IDX_W | Fetch-address index bits of the resolved branch |
| up_hist | input | HIST_W | Global history of the resolved branch |
| up_target | input | TGT_W | Resolved target |
| pr_valid | output | 1 | Prediction usable |
| pr_conf | output | CONF_W | Confidence of the slot read |
| pr_target | output | TGT_W | Stored target of the slot read |

## Verification
Every slot is filled and then read back through a different address/history pair with the same XOR. This shows whether the index hash is right and whether each slot is independent. One slot is then read under all 128 history values, which separates a true XOR index from one that ignores history. One slot is walked through the full counter sequence: strengthen to saturation, weaken to zero, then replace. This tells the hit, decrement and replace paths apart. A long pseudo-random mix confined to eight slots, with return flags and same-cycle read/write collisions, is compared against an arithmetic model of the requirements.

// File: rtl/itc_pkg.sv
package itc_pkg;

   // Action chosen for one resolved indirect branch
   typedef enum logic [2:0] {
      ACT_NONE       = 3'd0,
      ACT_ALLOC      = 3'd1,
      ACT_STRENGTHEN = 3'd2,
      ACT_WEAKEN     = 3'd3,
      ACT_REPLACE    = 3'd4
   } itc_act_e;

   function automatic logic act_writes_target(itc_act_e a);
      return (a == ACT_ALLOC) || (a == ACT_REPLACE);
   endfunction

endpackage

// File: rtl/itc_index.sv
module itc_index #(
   parameter int IDX_W  = 7,
   parameter int HIST_W = 7
) (
   input  logic [IDX_W-1:0]  fa,
   input  logic [HIST_W-1:0] hist,
   output logic [IDX_W-1:0]  idx
);
   localparam int NCHUNK = (HIST_W + IDX_W - 1) / IDX_W;
   localparam int PAD_W  = NCHUNK * IDX_W;

   logic [PAD_W-1:0] hist_pad;
   logic [IDX_W-1:0] chunk [NCHUNK];
   logic [IDX_W-1:0] folded;

   assign hist_pad = PAD_W'(hist);

   // Slice the padded history into IDX_W-wide chunks
   for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
      assign chunk[c] = hist_pad[c*IDX_W +: IDX_W];
   end

   // Fold all chunks together so a wide history still hashes into IDX_W bits
   always_comb begin
      folded = '0;
      for (int c = 0; c < NCHUNK; c++) begin
         folded = folded ^ chunk[c];
      end
   end

   assign idx = fa ^ folded;

endmodule

// File: rtl/itc_conf_step.sv
module itc_conf_step
   import itc_pkg::*;
#(
   parameter int CONF_W = 2,
   parameter int TGT_W  = 62
) (
   input  logic              req,
   input  logic              ent_vld,
   input  logic [CONF_W-1:0] ent_conf,
   input  logic [TGT_W-1:0]  ent_tgt,
   input  logic [TGT_W-1:0]  new_tgt,
   output itc_act_e          act,
   output logic [CONF_W-1:0] nxt_conf
);
   localparam logic [CONF_W-1:0] CONF_TOP  = {CONF_W{1'b1}};
   localparam logic [CONF_W-1:0] CONF_SEED = CONF_W'(1);

   logic same_tgt;
   assign same_tgt = (ent_tgt == new_tgt);

   always_comb begin
      act      = ACT_NONE;
      nxt_conf = ent_conf;
      if (req) begin
         if (!ent_vld) begin
            act      = ACT_ALLOC;
            nxt_conf = CONF_SEED;
         end else if (same_tgt) begin
            act = ACT_STRENGTHEN;
            if (ent_conf != CONF_TOP) begin
               nxt_conf = ent_conf + CONF_W'(1);
            end
         end else if (ent_conf != '0) begin
            act      = ACT_WEAKEN;
            nxt_conf = ent_conf - CONF_W'(1);
         end else begin
            act      = ACT_REPLACE;
            nxt_conf = CONF_SEED;
         end
      end
   end

endmodule

// File: rtl/itc_store.sv
module itc_store #(
   parameter int ENTRIES = 128,
   parameter int IDX_W   = 7,
   parameter int TGT_W   = 62,
   parameter int CONF_W  = 2
) (
   input  logic              clk,
   input  logic              rst,
   // read port used by lookups
   input  logic [IDX_W-1:0]  ra_idx,
   output logic              ra_vld,
   output logic [CONF_W-1:0] ra_conf,
   output logic [TGT_W-1:0]  ra_tgt,
   // read port used by the update path
   input  logic [IDX_W-1:0]  rb_idx,
   output logic              rb_vld,
   output logic [CONF_W-1:0] rb_conf,
   output logic [TGT_W-1:0]  rb_tgt,
   // write port
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_tgt_en,
   input  logic [CONF_W-1:0] wr_conf,
   input  logic [TGT_W-1:0]  wr_tgt,
   output logic [ENTRIES-1:0] vld_bits
);
   logic [CONF_W-1:0] conf_arr [ENTRIES];
   logic [TGT_W-1:0]  tgt_arr  [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      logic              sel;
      logic              v_r;
      logic [CONF_W-1:0] c_r;
      logic [TGT_W-1:0]  t_r;

      assign sel = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk) begin
         if (rst) begin
            v_r <= 1'b0;
            c_r <= '0;
         end else if (sel) begin
            v_r <= 1'b1;
            c_r <= wr_conf;
         end
      end

      always_ff @(posedge clk) begin
         if (sel && wr_tgt_en) begin
            t_r <= wr_tgt;
         end
      end

      assign vld_bits[e] = v_r;
      assign conf_arr[e] = c_r;
      assign tgt_arr[e]  = t_r;
   end

   // Reads see the state before this cycle's write
   assign ra_vld  = vld_bits[ra_idx];
   assign ra_conf = conf_arr[ra_idx];
   assign ra_tgt  = tgt_arr[ra_idx];

   assign rb_vld  = vld_bits[rb_idx];
   assign rb_conf = conf_arr[rb_idx];
   assign rb_tgt  = tgt_arr[rb_idx];

endmodule

// File: rtl/itc_predictor.sv
module itc_predictor
   import itc_pkg::*;
#(
   parameter int ENTRIES = 128,
   parameter int HIST_W  = 7,
   parameter int TGT_W   = 62,
   parameter int CONF_W  = 2,
   parameter int USE_MIN = 2,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              lk_valid,
   input  logic              lk_is_ret,
   input  logic [IDX_W-1:0]  lk_fa,
   input  logic [HIST_W-1:0] lk_hist,
   input  logic              up_valid,
   input  logic              up_is_ret,
   input  logic [IDX_W-1:0]  up_fa,
   input  logic [HIST_W-1:0] up_hist,
   input  logic [TGT_W-1:0]  up_target,
   output logic              pr_valid,
   output logic [CONF_W-1:0] pr_conf,
   output logic [TGT_W-1:0]  pr_target
);
   localparam int CONF_MAX = (1 << CONF_W) - 1;

   initial begin
      assert (ENTRIES == (1 << IDX_W))
         else $error("itc_predictor: ENTRIES must be a power of two");
      assert (ENTRIES >= 2)
         else $error("itc_predictor: ENTRIES must be at least 2");
      assert (HIST_W >= 1)
         else $error("itc_predictor: HIST_W must be at least 1");
      assert (CONF_W >= 1)
         else $error("itc_predictor: CONF_W must be at least 1");
      assert (USE_MIN >= 1 && USE_MIN <= CONF_MAX)
         else $error("itc_predictor: USE_MIN out of counter range");
   end

   logic [IDX_W-1:0]  lk_idx, up_idx;
   logic              lk_go, up_go;
   logic              ra_vld, rb_vld;
   logic [CONF_W-1:0] ra_conf, rb_conf, nxt_conf;
   logic [TGT_W-1:0]  ra_tgt, rb_tgt;
   logic [ENTRIES-1:0] vld_bits;
   itc_act_e          act;

   assign lk_go = lk_valid && !lk_is_ret;
   assign up_go = up_valid && !up_is_ret;

   itc_index #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_lk_index (
      .fa(lk_fa), .hist(lk_hist), .idx(lk_idx)
   );

   itc_index #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_up_index (
      .fa(up_fa), .hist(up_hist), .idx(up_idx)
   );

   itc_store #(
      .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TGT_W(TGT_W), .CONF_W(CONF_W)
   ) u_store (
      .clk      (clk),
      .rst      (rst),
      .ra_idx   (lk_idx),
      .ra_vld   (ra_vld),
      .ra_conf  (ra_conf),
      .ra_tgt   (ra_tgt),
      .rb_idx   (up_idx),
      .rb_vld   (rb_vld),
      .rb_conf  (rb_conf),
      .rb_tgt   (rb_tgt),
      .wr_en    (act != ACT_NONE),
      .wr_idx   (up_idx),
      .wr_tgt_en(act_writes_target(act)),
      .wr_conf  (nxt_conf),
      .wr_tgt   (up_target),
      .vld_bits (vld_bits)
   );

   itc_conf_step #(.CONF_W(CONF_W), .TGT_W(TGT_W)) u_step (
      .req     (up_go),
      .ent_vld (rb_vld),
      .ent_conf(rb_conf),
      .ent_tgt (rb_tgt),
      .new_tgt (up_target),
      .act     (act),
      .nxt_conf(nxt_conf)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pr_valid  <= 1'b0;
         pr_conf   <= '0;
         pr_target <= '0;
      end else if (lk_go && ra_vld) begin
         pr_valid  <= (ra_conf >= CONF_W'(USE_MIN));
         pr_conf   <= ra_conf;
         pr_target <= ra_tgt;
      end else begin
         pr_valid  <= 1'b0;
         pr_conf   <= '0;
         pr_target <= '0;
      end
   end

endmodule

// File: rtl/itc_checker.sv
module itc_checker #(
   parameter int ENTRIES = 128,
   parameter int CONF_W  = 2,
   parameter int USE_MIN = 2
) (
   input logic               clk,
   input logic               rst,
   input logic               lk_valid,
   input logic               lk_is_ret,
   input logic               up_valid,
   input logic               up_is_ret,
   input logic               pr_valid,
   input logic [CONF_W-1:0]  pr_conf,
   input logic [ENTRIES-1:0] vld_bits
);
   // R8
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (vld_bits == '0) && !pr_valid && (pr_conf == '0));

   // R7
   ret_lookup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (lk_valid && lk_is_ret) |=> !pr_valid && (pr_conf == '0));

   // R10
   idle_lookup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !lk_valid |=> !pr_valid && (pr_conf == '0));

   // R2
   use_threshold_chk: assert property (@(posedge clk) disable iff (rst)
      pr_valid |-> (pr_conf >= CONF_W'(USE_MIN)));

   // R7
   ret_update_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(up_valid && !up_is_ret) |=> $stable(vld_bits));

   // R3
   alloc_marks_chk: assert property (@(posedge clk) disable iff (rst)
      (up_valid && !up_is_ret) |=> (vld_bits != '0));

endmodule

bind itc_predictor itc_checker #(
   .ENTRIES(ENTRIES), .CONF_W(CONF_W), .USE_MIN(USE_MIN)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .lk_valid (lk_valid),
   .lk_is_ret(lk_is_ret),
   .up_valid (up_valid),
   .up_is_ret(up_is_ret),
   .pr_valid (pr_valid),
   .pr_conf  (pr_conf),
   .vld_bits (vld_bits)
);

// File: tb/tb_itc_predictor.sv
`timescale 1ns/1ps
module tb_itc_predictor;
   localparam int IDX_W   = 7;
   localparam int ENTRIES = 128;
   localparam int TGT_W   = 62;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic             lk_valid = 0, lk_is_ret = 0, up_valid = 0, up_is_ret = 0;
   logic [IDX_W-1:0] lk_fa = '0, lk_hist = '0, up_fa = '0, up_hist = '0;
   logic [TGT_W-1:0] up_target = '0;
   logic             pr_valid;
   logic [1:0]       pr_conf;
   logic [TGT_W-1:0] pr_target;

   itc_predictor dut (
      .clk(clk), .rst(rst),
      .lk_valid(lk_valid), .lk_is_ret(lk_is_ret), .lk_fa(lk_fa), .lk_hist(lk_hist),
      .up_valid(up_valid), .up_is_ret(up_is_ret), .up_fa(up_fa), .up_hist(up_hist),
      .up_target(up_target),
      .pr_valid(pr_valid), .pr_conf(pr_conf), .pr_target(pr_target)
   );

   int total = 0, bad = 0;
   bit done = 0;

   // reference model built from the requirements
   bit               m_v [ENTRIES];
   logic [TGT_W-1:0] m_t [ENTRIES];
   int               m_c [ENTRIES];

   logic             last_v;
   int               last_c;
   logic [TGT_W-1:0] last_t;

   function automatic logic [TGT_W-1:0] tgt_of(int i);
      return TGT_W'(64'h0123_4000_0000_0000 + 64'(i) * 64'h0000_0101_0003_0007);
   endfunction

   task automatic model_clear();
      for (int e = 0; e < ENTRIES; e++) begin
         m_v[e] = 0; m_c[e] = 0; m_t[e] = '0;
      end
   endtask

   task automatic model_update(int ix, logic [TGT_W-1:0] t);
      if (!m_v[ix]) begin
         m_v[ix] = 1; m_t[ix] = t; m_c[ix] = 1;          // R3
      end else if (m_t[ix] == t) begin
         if (m_c[ix] < 3) m_c[ix]++;                      // R4
      end else if (m_c[ix] > 0) begin
         m_c[ix]--;                                       // R5
      end else begin
         m_t[ix] = t; m_c[ix] = 1;                        // R6
      end
   endtask

   // one cycle: drive at negedge, sample at the next negedge (one register stage)
   task automatic step(input bit lv, input logic [IDX_W-1:0] lfa, input logic [IDX_W-1:0] lh,
                       input bit lr, input bit uv, input logic [IDX_W-1:0] ufa,
                       input logic [IDX_W-1:0] uh, input bit ur, input logic [TGT_W-1:0] ut,
                       input string tag);
      int li, ui;
      bit ev; int ec; logic [TGT_W-1:0] et;
      li = int'(lfa ^ lh);
      ui = int'(ufa ^ uh);
      ev = 0; ec = 0; et = '0;
      if (lv && !lr && m_v[li]) begin
         ev = (m_c[li] >= 2); ec = m_c[li]; et = m_t[li];
      end
      lk_valid = lv; lk_fa = lfa; lk_hist = lh; lk_is_ret = lr;
      up_valid = uv; up_fa = ufa; up_hist = uh; up_is_ret = ur; up_target = ut;
      @(negedge clk);
      last_v = pr_valid; last_c = int'(pr_conf); last_t = pr_target;
      total++;
      if (pr_valid !== ev || int'(pr_conf) != ec || pr_target !== et) begin
         bad++;
         $display("FAIL %s: got v=%0b c=%0d t=%h expected v=%0b c=%0d t=%h",
                  tag, pr_valid, pr_conf, pr_target, ev, ec, et);
      end
      if (uv && !ur) model_update(ui, ut);
   endtask

   task automatic lit(input string tag, input bit ev, input int ec, input logic [TGT_W-1:0] et);
      total++;
      if (last_v !== ev || last_c != ec || last_t !== et) begin
         bad++;
         $display("FAIL %s: got v=%0b c=%0d t=%h expected v=%0b c=%0d t=%h",
                  tag, last_v, last_c, last_t, ev, ec, et);
      end
   endtask

   task automatic upd(input int ix, input logic [TGT_W-1:0] t, input bit ur, input string tag);
      step(0, '0, '0, 0, 1, IDX_W'(ix) ^ 7'h2a, 7'h2a, ur, t, tag);
   endtask

   task automatic look(input int ix, input bit lr, input string tag);
      step(1, IDX_W'(ix) ^ 7'h51, 7'h51, lr, 0, '0, '0, 0, '0, tag);
   endtask

   task automatic do_reset();
      rst = 1;
      lk_valid = 0; up_valid = 0;
      @(negedge clk); @(negedge clk);
      total++;
      if (pr_valid !== 0 || pr_conf !== 0 || pr_target !== '0) begin
         bad++;
         $display("FAIL R8: outputs in reset v=%0b c=%0d t=%h expected 0 0 0",
                  pr_valid, pr_conf, pr_target);
      end
      rst = 0;
      model_clear();
   endtask

   initial begin
      logic [TGT_W-1:0] ta, tb;
      logic [31:0] lf;
      model_clear();
      @(negedge clk);
      do_reset();

      // R8: every slot empty after reset
      for (int i = 0; i < ENTRIES; i++) look(i, 0, "R8 empty");

      // R1 R3: fill every slot through one (fa,hist) pair, read back via another
      for (int i = 0; i < ENTRIES; i++)
         step(0, '0, '0, 0, 1, IDX_W'(i) ^ IDX_W'(i * 53), IDX_W'(i * 53), 0, tgt_of(i), "R3 alloc");
      for (int i = 0; i < ENTRIES; i++) begin
         step(1, IDX_W'(i) ^ IDX_W'(i * 11 + 3), IDX_W'(i * 11 + 3), 0, 0, '0, '0, 0, '0, "R1 alias");
         if (i == 9) lit("R3 seed conf", 0, 1, tgt_of(9));
      end

      // R4 R5 R6: counter walk on slot 9
      ta = tgt_of(9); tb = tgt_of(300);
      upd(9, ta, 0, "R4"); look(9, 0, "R4"); lit("R4 first hit", 1, 2, ta);
      upd(9, ta, 0, "R4"); look(9, 0, "R4"); lit("R4 second hit", 1, 3, ta);
      upd(9, ta, 0, "R4"); look(9, 0, "R4"); lit("R4 saturate", 1, 3, ta);
      upd(9, tb, 0, "R5"); look(9, 0, "R5"); lit("R5 weaken to 2", 1, 2, ta);
      upd(9, tb, 0, "R5"); look(9, 0, "R5"); lit("R5 weaken to 1", 0, 1, ta);
      upd(9, tb, 0, "R5"); look(9, 0, "R5"); lit("R5 weaken to 0", 0, 0, ta);
      upd(9, tb, 0, "R6"); look(9, 0, "R6"); lit("R6 replace", 0, 1, tb);

      // R7: return updates ignored, return lookups quiet
      upd(9, tgt_of(400), 1, "R7"); look(9, 0, "R7"); lit("R7 ret update ignored", 0, 1, tb);
      upd(9, tb, 0, "R7"); upd(9, tb, 0, "R7");
      look(9, 1, "R7"); lit("R7 ret lookup", 0, 0, '0);
      look(9, 0, "R7"); lit("R7 slot intact", 1, 3, tb);

      // R1: slot 9 under every history value
      for (int h = 0; h < ENTRIES; h++)
         step(1, IDX_W'(h) ^ 7'd9, IDX_W'(h), 0, 0, '0, '0, 0, '0, "R1 history sweep");

      // R9: same-cycle lookup and update of slot 20 (conf 1)
      step(1, 7'd20 ^ 7'h33, 7'h33, 0, 1, 7'd20 ^ 7'h0f, 7'h0f, 0, tgt_of(20), "R9");
      lit("R9 old value", 0, 1, tgt_of(20));
      look(20, 0, "R9"); lit("R9 new value", 1, 2, tgt_of(20));

      // R10: idle lookup while updating
      step(0, 7'd20, '0, 0, 1, 7'd20, '0, 0, tgt_of(20), "R10");
      lit("R10 idle", 0, 0, '0);

      // R2: pseudo-random mix over slots 64..71
      lf = 32'h1d87_2b41;
      for (int n = 0; n < 3000; n++) begin
         logic [IDX_W-1:0] lh, uh;
         int li, ui;
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         lh = lf[6:0]; uh = lf[13:7];
         li = 64 + int'(lf[16:14]); ui = 64 + int'(lf[19:17]);
         step(lf[20] | lf[21], IDX_W'(li) ^ lh, lh, lf[22] & lf[23] & lf[24],
              lf[25] | lf[26], IDX_W'(ui) ^ uh, uh, lf[27] & lf[28] & lf[29],
              tgt_of(500 + int'(lf[31:30]) % 3), "R2 mix");
      end

      // R8: reset mid-run clears everything
      do_reset();
      for (int i = 0; i < ENTRIES; i++) look(i, 0, "R8 cleared");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got no completion expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule